// File: doc/BRIEF.md
# Watchdog Timer with Power-Mode Gating

This block is the system watchdog of a small microcontroller. A crystal-derived clock drives a free-running prescaler. Each prescaler carry advances a timeout counter. When software stops writing the service strobe, the counter wraps and the block raises a one-cycle watchdog reset request, which the reset sequencer acts on.

The block follows the CPU's low-power state. In wait mode it keeps counting, so firmware must service it from an interrupt routine. A stop request removes the clock: the prescaler is cleared and the counter freezes until the CPU wakes.

A configuration input can forbid the stop instruction. A stop request then becomes a one-cycle illegal-opcode reset request. The watchdog is also held off, with both stages forced to zero, in these cases:
- a configuration bit turns it off;
- a break interrupt coincides with the high test voltage on the reset pin;
- monitor entry happens with the test voltage on the interrupt pin, for as long as that voltage stays present;
- monitor entry happens without that voltage, until the next system reset.

Top module: `wdt_lowpower`

## Requirements
- R1: While `rst` is high at a clock edge, all state is cleared: `wdt_rst`, `illop_rst` and `stop_active` are 0, both counting stages are zero, and any monitor-mode hold-off is released.
- R2: Counting starts from a cleared state. With no service and no hold-off, `wdt_rst` goes high for exactly one cycle after 2^(PRE_W+CNT_W) counting edges. The default widths are PRE_W=13 and CNT_W=6.
- R3: A high `svc_wr` at an edge clears both the prescaler and the counter. If the counter would overflow at that same edge, the service wins and no reset is raised.
- R4: `wait_req` has no effect: counting and the timeout proceed exactly as without it.
- R5: With `cfg_stop_forbid`=0, a `stop_req` pulse sets `stop_active` from the next cycle. It clears the prescaler and freezes the counter, and no reset occurs while stopped. Counting resumes from the edge after a `stop_exit` pulse, with the prescaler at zero and the counter at its frozen value.
- R6: With `cfg_stop_forbid`=1, a `stop_req` pulse raises `illop_rst` for exactly the next cycle. `stop_active` stays 0 and counting continues undisturbed.
- R7: While `brk_active` and `hv_on_rst` are both high, both stages are held at zero and no reset is raised. Either signal alone has no effect.
- R8: A `mon_entry` pulse with `hv_on_irq` high holds the watchdog off from the next edge while `hv_on_irq` stays high. Once the voltage is removed, a full timeout period follows.
- R9: A `mon_entry` pulse with `hv_on_irq` low holds the watchdog off until the next `rst`.
- R10: While `cfg_wdt_off` is high, both stages are held at zero and no reset is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Crystal-derived watchdog clock |
| rst | input | 1 | Synchronous active-high system reset |
| wait_req | input | 1 | CPU is in wait mode (level) |
| stop_req | input | 1 | Stop instruction executed (one-cycle pulse) |
| stop_exit | input | 1 | Wake-up from stop (one-cycle pulse) |
| cfg_stop_forbid | input | 1 | Configuration: stop instruction is illegal |
| cfg_wdt_off | input | 1 | Configuration: watchdog turned off |
| brk_active | input | 1 | Break interrupt in progress |
| hv_on_rst | input | 1 | Test voltage detected on the reset pin |
| hv_on_irq | input | 1 | Test voltage detected on the interrupt pin |
| mon_entry | input | 1 | Monitor mode is being entered (one-cycle pulse) |
| svc_wr | input | 1 | Write strobe to the service register |
| wdt_rst | output | 1 | Watchdog reset request, one cycle |
| illop_rst | output | 1 | Illegal-opcode reset request, one cycle |
| stop_active | output | 1 | Watchdog clock gated by stop mode |

## Verification
A corrupted prescaler or counter shows only as a shifted reset instant, so every timeout is measured to the exact edge against 2^(PRE_W+CNT_W). A counter that fails to freeze or clear in stop mode moves the reset earlier or later by whole multiples of the prescaler period, and this shows within one timeout of waking. A stuck hold-off latch shows as either a missing reset across a window longer than the timeout, or a reset inside a held-off window.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  // Control bundle produced by the mode gate for the counting stages.
  typedef struct packed {
    logic hold_off;    // watchdog disabled: stages forced to zero
    logic run;         // prescaler advances this edge
    logic stop_enter;  // stop accepted this edge: prescaler cleared
    logic stopped;     // clock gated by stop mode
  } wdt_ctl_t;
endpackage

// File: rtl/wdt_gate.sv
module wdt_gate
  import wdt_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      stop_req,
  input  logic      stop_exit,
  input  logic      cfg_stop_forbid,
  input  logic      cfg_wdt_off,
  input  logic      brk_active,
  input  logic      hv_on_rst,
  input  logic      hv_on_irq,
  input  logic      mon_entry,
  output wdt_ctl_t  ctl,
  output logic      illop_rst
);
  logic stopped_q, illop_q, mon_hv_q, mon_blank_q;
  logic stop_enter, hold_off;

  assign stop_enter = stop_req && !cfg_stop_forbid && !stopped_q;
  assign hold_off   = cfg_wdt_off
                   || (brk_active && hv_on_rst)
                   || (mon_hv_q && hv_on_irq)
                   || mon_blank_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      stopped_q   <= 1'b0;
      illop_q     <= 1'b0;
      mon_hv_q    <= 1'b0;
      mon_blank_q <= 1'b0;
    end else begin
      if (stop_enter)     stopped_q <= 1'b1;
      else if (stop_exit) stopped_q <= 1'b0;
      illop_q <= stop_req && cfg_stop_forbid;
      // Test-voltage monitor entry: held off while the voltage lasts.
      if (mon_entry && hv_on_irq) mon_hv_q <= 1'b1;
      else if (!hv_on_irq)        mon_hv_q <= 1'b0;
      // Vector-based monitor entry: held off until system reset.
      if (mon_entry && !hv_on_irq) mon_blank_q <= 1'b1;
    end
  end

  assign ctl.hold_off   = hold_off;
  assign ctl.stop_enter = stop_enter;
  assign ctl.stopped    = stopped_q;
  assign ctl.run        = !hold_off && !stopped_q && !stop_enter;
  assign illop_rst      = illop_q;

  assert_illop_pulse_R6: assert property (@(posedge clk) disable iff (rst)
    (stop_req && cfg_stop_forbid && !stopped_q) |=> (illop_rst && !ctl.stopped));

  assert_blank_holds_R9: assert property (@(posedge clk) disable iff (rst)
    (mon_entry && !hv_on_irq) |=> ctl.hold_off);
endmodule

// File: rtl/wdt_prescaler.sv
module wdt_prescaler #(
  parameter int PRE_W = 13
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             run,
  output logic [PRE_W-1:0] pre,
  output logic             carry
);
  localparam logic [PRE_W-1:0] PRE_MAX = {PRE_W{1'b1}};
  logic [PRE_W-1:0] pre_q;

  always_ff @(posedge clk) begin
    if (rst || clr)  pre_q <= '0;
    else if (run)    pre_q <= pre_q + 1'b1;
  end

  assign pre   = pre_q;
  assign carry = run && !clr && (pre_q == PRE_MAX);

  assert_clear_zero_R3: assert property (@(posedge clk) disable iff (rst)
    clr |=> (pre == '0));
endmodule

// File: rtl/wdt_counter.sv
module wdt_counter #(
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             tick,
  output logic [CNT_W-1:0] cnt,
  output logic             wdt_rst
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  logic [CNT_W-1:0] cnt_q;
  logic             fire_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      fire_q <= 1'b0;
    end else begin
      fire_q <= tick && !clr && (cnt_q == CNT_MAX);
      if (clr)       cnt_q <= '0;
      else if (tick) cnt_q <= cnt_q + 1'b1;
    end
  end

  assign cnt     = cnt_q;
  assign wdt_rst = fire_q;

  assert_service_wins_R3: assert property (@(posedge clk) disable iff (rst)
    clr |=> !wdt_rst);
endmodule

// File: rtl/wdt_lowpower.sv
module wdt_lowpower #(
  parameter int PRE_W = 13,
  parameter int CNT_W = 6
) (
  input  logic clk,
  input  logic rst,
  input  logic wait_req,
  input  logic stop_req,
  input  logic stop_exit,
  input  logic cfg_stop_forbid,
  input  logic cfg_wdt_off,
  input  logic brk_active,
  input  logic hv_on_rst,
  input  logic hv_on_irq,
  input  logic mon_entry,
  input  logic svc_wr,
  output logic wdt_rst,
  output logic illop_rst,
  output logic stop_active
);
  import wdt_pkg::*;

  wdt_ctl_t         ctl;
  logic [PRE_W-1:0] pre;
  logic [CNT_W-1:0] cnt;
  logic             carry;
  logic             pre_clr, cnt_clr;

  assign pre_clr = ctl.hold_off || svc_wr || ctl.stop_enter;
  assign cnt_clr = ctl.hold_off || svc_wr;

  wdt_gate u_gate (
    .clk(clk), .rst(rst),
    .stop_req(stop_req), .stop_exit(stop_exit),
    .cfg_stop_forbid(cfg_stop_forbid), .cfg_wdt_off(cfg_wdt_off),
    .brk_active(brk_active), .hv_on_rst(hv_on_rst),
    .hv_on_irq(hv_on_irq), .mon_entry(mon_entry),
    .ctl(ctl), .illop_rst(illop_rst)
  );

  wdt_prescaler #(.PRE_W(PRE_W)) u_pre (
    .clk(clk), .rst(rst), .clr(pre_clr), .run(ctl.run),
    .pre(pre), .carry(carry)
  );

  wdt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .clr(cnt_clr), .tick(carry),
    .cnt(cnt), .wdt_rst(wdt_rst)
  );

  assign stop_active = ctl.stopped;

  assert_single_pulse_R2: assert property (@(posedge clk) disable iff (rst)
    wdt_rst |=> !wdt_rst);

  assert_wait_counts_R4: assert property (@(posedge clk) disable iff (rst)
    (wait_req && ctl.run && !svc_wr) |=> (pre != $past(pre)));

  assert_stop_freeze_R5: assert property (@(posedge clk) disable iff (rst)
    (stop_active && !svc_wr && !ctl.hold_off) |=> ($stable(cnt) && !wdt_rst));

  assert_break_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (brk_active && hv_on_rst) |=> (!wdt_rst && pre == '0 && cnt == '0));

  assert_off_hold_R10: assert property (@(posedge clk) disable iff (rst)
    cfg_wdt_off |=> (!wdt_rst && cnt == '0));
endmodule

// File: tb/tb_wdt_lowpower.sv
module tb_wdt_lowpower;
  localparam int P = 4;
  localparam int C = 3;
  localparam int PERIOD = 1 << (P + C);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wait_req = 0, stop_req = 0, stop_exit = 0, cfg_stop_forbid = 0;
  logic cfg_wdt_off = 0, brk_active = 0, hv_on_rst = 0, hv_on_irq = 0;
  logic mon_entry = 0, svc_wr = 0;
  logic wdt_rst, illop_rst, stop_active;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #10 clk = ~clk;  // 50 MHz

  wdt_lowpower #(.PRE_W(P), .CNT_W(C)) dut (
    .clk(clk), .rst(rst), .wait_req(wait_req), .stop_req(stop_req),
    .stop_exit(stop_exit), .cfg_stop_forbid(cfg_stop_forbid),
    .cfg_wdt_off(cfg_wdt_off), .brk_active(brk_active),
    .hv_on_rst(hv_on_rst), .hv_on_irq(hv_on_irq), .mon_entry(mon_entry),
    .svc_wr(svc_wr), .wdt_rst(wdt_rst), .illop_rst(illop_rst),
    .stop_active(stop_active)
  );

  // Edges left until timeout after a stop that followed n counting edges.
  function automatic int left_after_stop(input int n);
    return ((1 << C) - (n >> P)) * (1 << P);
  endfunction

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Counts edges until wdt_rst is seen; -1 when none within lim.
  task automatic measure(input int lim, output int n);
    int k = 0;
    n = -1;
    while (k < lim) begin
      tick();
      k++;
      if (wdt_rst) begin
        n = k;
        break;
      end
    end
  endtask

  task automatic service();
    svc_wr = 1;
    tick();
    svc_wr = 0;
  endtask

  task automatic do_reset();
    rst = 1;
    tick();
    rst = 0;
  endtask

  initial begin
    int n;
    int r;
    r = $urandom(32'd2024);
    @(negedge clk);
    tick(); tick();
    rst = 0;
    check(!wdt_rst && !illop_rst && !stop_active, "R1", int'(wdt_rst), 0);
    measure(PERIOD + 50, n);
    check(n == PERIOD, "R1", n, PERIOD);
    tick();
    check(!wdt_rst, "R2", int'(wdt_rst), 0);

    // R2 plain timeout after service
    service();
    measure(PERIOD + 50, n);
    check(n == PERIOD, "R2", n, PERIOD);

    // R4 wait mode does not change the timeout
    wait_req = 1;
    service();
    measure(PERIOD + 50, n);
    check(n == PERIOD, "R4", n, PERIOD);
    wait_req = 0;

    // R3 service on the overflow edge
    service();
    measure(PERIOD - 1, n);
    check(n == -1, "R3", n, -1);
    svc_wr = 1;
    tick();
    svc_wr = 0;
    check(!wdt_rst, "R3", int'(wdt_rst), 0);
    measure(PERIOD + 50, n);
    check(n == PERIOD, "R3", n, PERIOD);

    // R3 random early servicing keeps reset away
    service();
    for (int i = 0; i < 6; i++) begin
      int gap = $urandom_range(PERIOD - 2, 1);
      measure(gap, n);
      check(n == -1, "R3", n, -1);
      service();
    end
    measure(PERIOD + 50, n);
    check(n == PERIOD, "R3", n, PERIOD);

    // R5 stop mode freezes counter, clears prescaler
    for (int i = 0; i < 5; i++) begin
      int cnt_n = (i == 0) ? 0 : $urandom_range(PERIOD - 1, 0);
      service();
      repeat (cnt_n) tick();
      stop_req = 1;
      tick();
      stop_req = 0;
      check(stop_active, "R5", int'(stop_active), 1);
      measure(300, n);
      check(n == -1, "R5", n, -1);
      stop_exit = 1;
      tick();
      stop_exit = 0;
      check(!stop_active, "R5", int'(stop_active), 0);
      measure(PERIOD + 50, n);
      check(n == left_after_stop(cnt_n), "R5", n, left_after_stop(cnt_n));
    end

    // R6 forbidden stop: illegal-opcode pulse, counting undisturbed
    cfg_stop_forbid = 1;
    for (int i = 0; i < 3; i++) begin
      int cnt_n = $urandom_range(99, 0);
      service();
      repeat (cnt_n) tick();
      stop_req = 1;
      tick();
      stop_req = 0;
      check(illop_rst && !stop_active, "R6", int'(illop_rst), 1);
      tick();
      check(!illop_rst, "R6", int'(illop_rst), 0);
      measure(PERIOD + 50, n);
      check(n == PERIOD - cnt_n - 2, "R6", n, PERIOD - cnt_n - 2);
    end
    cfg_stop_forbid = 0;

    // R7 break alone does not disable; break with test voltage does
    service();
    brk_active = 1;
    measure(PERIOD + 50, n);
    check(n == PERIOD, "R7", n, PERIOD);
    hv_on_rst = 1;
    measure(300, n);
    check(n == -1, "R7", n, -1);
    brk_active = 0;
    measure(PERIOD + 50, n);
    check(n == PERIOD, "R7", n, PERIOD);
    hv_on_rst = 0;

    // R8 monitor entry with test voltage on interrupt pin
    service();
    hv_on_irq = 1;
    mon_entry = 1;
    tick();
    mon_entry = 0;
    measure(300, n);
    check(n == -1, "R8", n, -1);
    hv_on_irq = 0;
    measure(PERIOD + 50, n);
    check(n == PERIOD, "R8", n, PERIOD);

    // R9 monitor entry without test voltage: held until reset
    mon_entry = 1;
    tick();
    mon_entry = 0;
    measure(500, n);
    check(n == -1, "R9", n, -1);
    do_reset();
    measure(PERIOD + 50, n);
    check(n == PERIOD, "R9", n, PERIOD);

    // R10 configuration off
    cfg_wdt_off = 1;
    measure(300, n);
    check(n == -1, "R10", n, -1);
    cfg_wdt_off = 0;
    measure(PERIOD + 50, n);
    check(n == PERIOD, "R10", n, PERIOD);

    // R1 reset mid-stop clears stop state
    stop_req = 1;
    tick();
    stop_req = 0;
    do_reset();
    check(!stop_active && !wdt_rst && !illop_rst, "R1", int'(stop_active), 0);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule